// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds a small set of hardware lock flags that two independent ports share. Software on either side uses a flag to claim a shared resource, checks whether the claim succeeded, and gives the flag back when it is done. Both ports run on one clock. Each port makes at most one flag access per cycle, and that access is a claim, a give-back or a read.

Each flag records which side holds it. When a port claims a flag that the other side holds, the bank remembers the claim and hands the flag across as soon as the holder gives it back. If both ports claim the same free flag in the same cycle, a rotating priority bit picks exactly one of them. The bit flips after every such tie, so neither side can be starved. Each side reads its own view of a flag: 0 means "mine" and 1 means "free or held by the other side".

Top module: `sem_bank`

## Requirements
- R1: There are 2^ADDR_W flags (eight by default), chosen by the port's address. An access happens only when that port's select `*_sem_n` is low. An access with `*_sem_n` high has no effect.
- R2: After synchronous reset every flag is free, no claim is waiting, the tie priority favours port A, and both `*_rdata` outputs are 1.
- R3: A write (`*_wr_n` low) with `*_wdata` = 0 is a claim. A claim on a free flag, with no competing claim, gives that flag to the claiming port at the next clock edge.
- R4: A read (`*_wr_n` high) sets that port's `*_rdata` one clock later. It is 0 if the port holds the addressed flag and 1 otherwise. `*_rdata` keeps its value in cycles with no read.
- R5: Same-cycle claims by both ports on the same free flag grant it to exactly one port. Port A wins when the priority bit is 0 and port B wins when it is 1. The bit flips after each tie.
- R6: A claim on a flag the other port holds is remembered, and this includes the losing claim of a tie. The flag passes straight to the waiting port when the holder gives it back.
- R7: A write with `*_wdata` = 1 from the holding port gives the flag back. The flag becomes free unless the other port is waiting or is claiming it in that same cycle.
- R8: A give-back from the port that does not hold the flag has no effect on ownership or on waiting claims.
- R9: Claims by the two ports on different flags in the same cycle are independent, and both succeed when those flags are free.
- R10: An access made while that port's `*_ce_n` is low (memory enabled) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| a_sem_n | input | 1 | Port A flag select, active low |
| a_ce_n | input | 1 | Port A memory enable, active low; must be high for a flag access |
| a_wr_n | input | 1 | Port A write strobe, low = write, high = read |
| a_addr | input | ADDR_W | Port A flag index |
| a_wdata | input | 1 | Port A write bit: 0 claims, 1 gives back |
| a_rdata | output | 1 | Port A registered read result |
| b_sem_n | input | 1 | Port B flag select, active low |
| b_ce_n | input | 1 | Port B memory enable, active low; must be high for a flag access |
| b_wr_n | input | 1 | Port B write strobe, low = write, high = read |
| b_addr | input | ADDR_W | Port B flag index |
| b_wdata | input | 1 | Port B write bit: 0 claims, 1 gives back |
| b_rdata | output | 1 | Port B registered read result |

## Verification
On every cycle the assertions check the following:
- A waiting claim exists only against a flag the other side holds.
- A tie always leaves the flag owned and flips the priority bit.
- A lone claim on a free flag is granted, and a waiting claim is served on give-back.
- A give-back from the non-holder leaves the holder in place.
- Each port's decoded access is one-hot and is suppressed while memory is enabled.
- `*_rdata` stays stable in cycles with no read.

Some properties show only at the ports, through the bench's behavioural model and its scenarios. One is which side wins alternating ties. Others are the exact read value seen from each side, the independence of claims to different flags, and the reset view of all eight flags.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'b00,
    SEM_OWN_A = 2'b01,
    SEM_OWN_B = 2'b10
  } sem_owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sem_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata,
  output logic [NUM-1:0]    req,
  output logic [NUM-1:0]    rel,
  output logic              rd_en
);
  logic acc;
  assign acc   = ~sem_n & ce_n;
  assign rd_en = acc & wr_n;

  for (genvar i = 0; i < NUM; i++) begin : g_dec
    logic hit;
    assign hit    = acc & ~wr_n & (addr == ADDR_W'(i));
    assign req[i] = hit & ~wdata;
    assign rel[i] = hit & wdata;
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req | rel)) else $error("one access per port per cycle"); // R1
  AST_CE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !ce_n |-> ((req | rel) == '0 && !rd_en)) else $error("access while memory enabled"); // R10
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       prio,
  input  logic       req_a,
  input  logic       rel_a,
  input  logic       req_b,
  input  logic       rel_b,
  output sem_owner_e owner,
  output logic       tie
);
  sem_owner_e own_q, own_d;
  logic       wait_a_q, wait_a_d, wait_b_q, wait_b_d;

  always_comb begin
    own_d    = own_q;
    wait_a_d = wait_a_q;
    wait_b_d = wait_b_q;
    tie      = 1'b0;
    unique case (own_q)
      SEM_FREE: begin
        if (req_a && req_b) begin
          tie = 1'b1;
          if (!prio) begin
            own_d    = SEM_OWN_A;
            wait_b_d = 1'b1;
          end else begin
            own_d    = SEM_OWN_B;
            wait_a_d = 1'b1;
          end
        end else if (req_a) begin
          own_d = SEM_OWN_A;
        end else if (req_b) begin
          own_d = SEM_OWN_B;
        end
      end
      SEM_OWN_A: begin
        if (rel_a) begin
          if (wait_b_q || req_b) begin
            own_d    = SEM_OWN_B;
            wait_b_d = 1'b0;
          end else begin
            own_d = SEM_FREE;
          end
        end else if (req_b) begin
          wait_b_d = 1'b1;
        end
      end
      SEM_OWN_B: begin
        if (rel_b) begin
          if (wait_a_q || req_a) begin
            own_d    = SEM_OWN_A;
            wait_a_d = 1'b0;
          end else begin
            own_d = SEM_FREE;
          end
        end else if (req_a) begin
          wait_a_d = 1'b1;
        end
      end
      default: begin
        own_d    = SEM_FREE;
        wait_a_d = 1'b0;
        wait_b_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= SEM_FREE;
      wait_a_q <= 1'b0;
      wait_b_q <= 1'b0;
    end else begin
      own_q    <= own_d;
      wait_a_q <= wait_a_d;
      wait_b_q <= wait_b_d;
    end
  end

  assign owner = own_q;

  AST_WAIT_A_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    wait_a_q |-> own_q == SEM_OWN_B) else $error("A waits on non-B flag"); // R6
  AST_WAIT_B_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
    wait_b_q |-> own_q == SEM_OWN_A) else $error("B waits on non-A flag"); // R6
  AST_TIE_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
    (own_q == SEM_FREE && req_a && req_b) |=> (own_q == SEM_OWN_A || own_q == SEM_OWN_B))
    else $error("tie left flag unowned"); // R5
  AST_LONE_GRANT_A: assert property (@(posedge clk) disable iff (rst)
    (own_q == SEM_FREE && req_a && !req_b) |=> own_q == SEM_OWN_A) else $error("lone claim lost"); // R3
  AST_HANDOVER_B: assert property (@(posedge clk) disable iff (rst)
    (own_q == SEM_OWN_A && rel_a && wait_b_q) |=> own_q == SEM_OWN_B) else $error("no handover to B"); // R6
  AST_NONOWNER_REL: assert property (@(posedge clk) disable iff (rst)
    (own_q == SEM_OWN_B && rel_a && !rel_b) |=> own_q == SEM_OWN_B) else $error("non-holder give-back acted"); // R8
endmodule

// File: rtl/sem_prio.sv
module sem_prio #(
  parameter int NUM = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] tie,
  output logic           prio
);
  always_ff @(posedge clk) begin
    if (rst)       prio <= 1'b0;
    else if (|tie) prio <= ~prio;
  end

  AST_SINGLE_TIE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tie)) else $error("more than one tie in a cycle"); // R5
  AST_PRIO_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (|tie) |=> prio != $past(prio)) else $error("priority did not flip"); // R5
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int ADDR_W = 3,
  localparam int NUM = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NUM-1:0]    mine,
  output logic              rdata
);
  always_ff @(posedge clk) begin
    if (rst)        rdata <= 1'b1;
    else if (rd_en) rdata <= ~mine[addr];
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)) else $error("rdata moved without a read"); // R4
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_sem_n,
  input  logic              a_ce_n,
  input  logic              a_wr_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wdata,
  output logic              a_rdata,
  input  logic              b_sem_n,
  input  logic              b_ce_n,
  input  logic              b_wr_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wdata,
  output logic              b_rdata
);
  localparam int NUM = 1 << ADDR_W;

  logic [NUM-1:0] req_a, rel_a, req_b, rel_b, tie, mine_a, mine_b;
  logic           rd_a, rd_b, prio;

  sem_port_dec #(.ADDR_W(ADDR_W)) u_dec_a (
    .clk(clk), .rst(rst), .sem_n(a_sem_n), .ce_n(a_ce_n), .wr_n(a_wr_n),
    .addr(a_addr), .wdata(a_wdata), .req(req_a), .rel(rel_a), .rd_en(rd_a));

  sem_port_dec #(.ADDR_W(ADDR_W)) u_dec_b (
    .clk(clk), .rst(rst), .sem_n(b_sem_n), .ce_n(b_ce_n), .wr_n(b_wr_n),
    .addr(b_addr), .wdata(b_wdata), .req(req_b), .rel(rel_b), .rd_en(rd_b));

  sem_prio #(.NUM(NUM)) u_prio (.clk(clk), .rst(rst), .tie(tie), .prio(prio));

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    sem_owner_e own;
    sem_flag_cell u_cell (
      .clk(clk), .rst(rst), .prio(prio),
      .req_a(req_a[i]), .rel_a(rel_a[i]), .req_b(req_b[i]), .rel_b(rel_b[i]),
      .owner(own), .tie(tie[i]));
    assign mine_a[i] = (own == SEM_OWN_A);
    assign mine_b[i] = (own == SEM_OWN_B);
  end

  sem_readback #(.ADDR_W(ADDR_W)) u_rb_a (
    .clk(clk), .rst(rst), .rd_en(rd_a), .addr(a_addr), .mine(mine_a), .rdata(a_rdata));

  sem_readback #(.ADDR_W(ADDR_W)) u_rb_b (
    .clk(clk), .rst(rst), .rd_en(rd_b), .addr(b_addr), .mine(mine_b), .rdata(b_rdata));
endmodule

// File: tb/sem_bank_tb.sv
`timescale 1ns/1ps
module sem_bank_tb;
  // operation kinds used by the bench
  localparam int K_IDLE = 0, K_REQ = 1, K_REL = 2, K_RD = 3, K_CE = 4, K_NOSEL = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_sem_n = 1'b1, a_ce_n = 1'b1, a_wr_n = 1'b1, a_wdata = 1'b1;
  logic b_sem_n = 1'b1, b_ce_n = 1'b1, b_wr_n = 1'b1, b_wdata = 1'b1;
  logic [2:0] a_addr = '0, b_addr = '0;
  logic a_rdata, b_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string tag = "R2";

  // behavioural reference: 0 free, 1 held by A, 2 held by B
  int own [8];
  bit waiting [2][8];
  bit prio_m;
  bit exp_r [2];

  always #2 clk = ~clk;

  sem_bank #(.ADDR_W(3)) u_dut (
    .clk(clk), .rst(rst),
    .a_sem_n(a_sem_n), .a_ce_n(a_ce_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sem_n(b_sem_n), .b_ce_n(b_ce_n), .b_wr_n(b_wr_n), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata));

  task automatic check(input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic void pins(input int k, output logic s, output logic c,
                               output logic w, output logic d);
    s = 1'b0; c = 1'b1; w = 1'b1; d = 1'b1;
    case (k)
      K_REQ:   begin w = 1'b0; d = 1'b0; end
      K_REL:   begin w = 1'b0; d = 1'b1; end
      K_RD:    begin w = 1'b1; end
      K_CE:    begin c = 1'b0; w = 1'b0; d = 1'b0; end
      K_NOSEL: begin s = 1'b1; w = 1'b0; d = 1'b0; end
      default: begin s = 1'b1; end
    endcase
  endfunction

  task automatic model_step(input int ka, input int aa, input int kb, input int ba);
    int kind [2];
    int adr [2];
    kind[0] = ka; kind[1] = kb; adr[0] = aa; adr[1] = ba;
    for (int p = 0; p < 2; p++)
      if (kind[p] == K_RD) exp_r[p] = (own[adr[p]] == p + 1) ? 1'b0 : 1'b1;
    for (int p = 0; p < 2; p++)
      if (kind[p] == K_REL && own[adr[p]] == p + 1) begin
        if (waiting[1-p][adr[p]]) begin
          own[adr[p]] = 2 - p;
          waiting[1-p][adr[p]] = 0;
        end else own[adr[p]] = 0;
      end
    if (ka == K_REQ && kb == K_REQ && aa == ba && own[aa] == 0) begin
      int win;
      win = prio_m ? 1 : 0;
      own[aa] = win + 1;
      waiting[1-win][aa] = 1;
      prio_m = ~prio_m;
    end else begin
      for (int p = 0; p < 2; p++)
        if (kind[p] == K_REQ) begin
          if (own[adr[p]] == 0) own[adr[p]] = p + 1;
          else if (own[adr[p]] != p + 1) waiting[p][adr[p]] = 1;
        end
    end
  endtask

  task automatic op(input int ka, input int aa, input int kb, input int ba);
    logic s, c, w, d;
    @(negedge clk);
    pins(ka, s, c, w, d);
    a_sem_n = s; a_ce_n = c; a_wr_n = w; a_wdata = d; a_addr = 3'(aa);
    pins(kb, s, c, w, d);
    b_sem_n = s; b_ce_n = c; b_wr_n = w; b_wdata = d; b_addr = 3'(ba);
    @(posedge clk);
    model_step(ka, aa, kb, ba);
    #1;
    check(a_rdata, exp_r[0], "a_rdata");
    check(b_rdata, exp_r[1], "b_rdata");
  endtask

  task automatic both_read(input int f);
    op(K_RD, f, K_RD, f);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin own[i] = 0; waiting[0][i] = 0; waiting[1][i] = 0; end
    prio_m = 0; exp_r[0] = 1; exp_r[1] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    tag = "R2";
    check(a_rdata, 1'b1, "reset a_rdata");
    check(b_rdata, 1'b1, "reset b_rdata");
    for (int f = 0; f < 8; f++) both_read(f);

    tag = "R3";
    op(K_REQ, 2, K_IDLE, 0);
    tag = "R4";
    both_read(2);
    op(K_IDLE, 0, K_IDLE, 0);
    tag = "R7";
    op(K_REL, 2, K_IDLE, 0);
    both_read(2);

    tag = "R5";
    op(K_REQ, 5, K_REQ, 5);
    both_read(5);
    tag = "R6";
    op(K_REL, 5, K_IDLE, 0);
    both_read(5);
    op(K_IDLE, 0, K_REL, 5);
    both_read(5);
    tag = "R5";
    op(K_REQ, 5, K_REQ, 5);
    both_read(5);
    tag = "R6";
    op(K_IDLE, 0, K_REL, 5);
    both_read(5);
    op(K_REL, 5, K_IDLE, 0);
    both_read(5);
    tag = "R5";
    op(K_REQ, 4, K_REQ, 4);
    both_read(4);
    op(K_REL, 4, K_IDLE, 0);
    both_read(4);
    op(K_IDLE, 0, K_REL, 4);

    tag = "R8";
    op(K_REQ, 1, K_IDLE, 0);
    op(K_IDLE, 0, K_REL, 1);
    both_read(1);
    op(K_REL, 1, K_IDLE, 0);
    both_read(1);

    tag = "R7";
    op(K_IDLE, 0, K_REQ, 7);
    op(K_REQ, 7, K_IDLE, 0);
    op(K_IDLE, 0, K_REL, 7);
    both_read(7);
    op(K_REL, 7, K_IDLE, 0);
    both_read(7);

    tag = "R9";
    op(K_REQ, 3, K_REQ, 6);
    op(K_RD, 3, K_RD, 6);
    op(K_RD, 6, K_RD, 3);
    op(K_REL, 3, K_REL, 6);
    op(K_RD, 3, K_RD, 6);

    tag = "R10";
    op(K_CE, 0, K_CE, 0);
    both_read(0);
    op(K_REQ, 0, K_IDLE, 0);
    op(K_RD, 0, K_CE, 0);
    both_read(0);
    op(K_REL, 0, K_IDLE, 0);

    tag = "R1";
    op(K_NOSEL, 6, K_NOSEL, 6);
    both_read(6);
    for (int f = 0; f < 8; f++) op(K_REQ, f, K_IDLE, 0);
    for (int f = 0; f < 8; f++) op(K_RD, f, K_RD, 7 - f);
    for (int f = 0; f < 8; f++) op(K_REL, f, K_REQ, f);
    for (int f = 0; f < 8; f++) both_read(f);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule